// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Controller

This controller accepts one 64-bit instruction word at a time and decides how it reaches the execution units. A word holds either two 32-bit short instructions or a single long instruction. Two format bits in the word choose among four issue plans. In the parallel plan both halves go out in the same cycle, the upper half to the memory unit and the lower half to the integer unit. In the two ordered plans one half is issued, its result is committed, and then the other half is issued to whichever unit is free. In the long plan the whole word goes out as one step.

The execution units report back in the same cycle as each issue step. A slot reports whether it redirects the program counter, the target address, and, for slot A only, a flag that suppresses the rest of the pair. The controller raises a commit strobe one cycle after every issue step. When the word is finished it raises a done strobe, together with the merged next-PC result and a conflict flag. The conflict flag is set when both parallel slots try to redirect.

A ready/valid handshake at the input holds off the next word while a sequence is in flight.

Top module: `dual_issue_ctrl`

## Requirements
- R1: After reset `word_ready` is 1 and `mem_go`, `int_go`, `any_go`, `long_go`, `commit`, `done`, `npc_valid` and `conflict` are all 0.
- R2: The format code is {`word_in[63]`, `word_in[31]`}. Code 3 (long) raises `long_go` alone, one cycle after the word is accepted, with `long_op` equal to the whole word. A long word gets exactly one commit.
- R3: Code 0 (parallel) raises `mem_go` and `int_go` together, one cycle after the word is accepted. `mem_op` carries bits 63:32 and `int_op` carries bits 31:0. A parallel word gets exactly one commit.
- R4: Code 1 (left first) issues bits 63:32 on `mem_go`/`mem_op` as step one. Step two, when it happens, issues bits 31:0 on `any_go`/`any_op` in the cycle after step one.
- R5: Code 2 (right first) issues bits 31:0 on `int_go`/`int_op` as step one. Step two, when it happens, issues bits 63:32 on `any_go`/`any_op` in the cycle after step one.
- R6: `commit` is high in the cycle after every issue step and at no other time. An ordered pair that is not cancelled therefore commits twice.
- R7: In the ordered modes, step two is skipped when step one reports `ra_branch` or `ra_kill`. `done` then follows step one directly, and `npc` takes `ra_target` when `ra_branch` was set.
- R8: In parallel mode, when exactly one slot reports a branch, `npc_valid` is 1 and `npc` is that slot's target (slot A is the memory unit, slot B the integer unit). When neither slot branches, `npc_valid` is 0.
- R9: In parallel mode, when both slots branch, `conflict` is 1 and `npc_valid` is 0, both in the `done` cycle.
- R10: `word_ready` is 0 while any step of a word is in flight. `word_valid` asserted during that time is ignored: no extra issue and no extra `done`.
- R11: `ra_kill` has no effect in the parallel mode, in the long mode, or during step two. For an ordered pair, the result reported in step two sets `npc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Instruction word offered |
| word_ready | output | 1 | Controller can take a word |
| word_in | input | 64 | Instruction word |
| mem_go | output | 1 | Issue strobe, memory unit |
| mem_op | output | 32 | Instruction for memory unit (0 when idle) |
| int_go | output | 1 | Issue strobe, integer unit |
| int_op | output | 32 | Instruction for integer unit (0 when idle) |
| any_go | output | 1 | Issue strobe, second step to any unit |
| any_op | output | 32 | Instruction for second step (0 when idle) |
| long_go | output | 1 | Issue strobe, long instruction |
| long_op | output | 64 | Long instruction (0 when idle) |
| ra_branch | input | 1 | Slot A result: redirect requested |
| ra_target | input | 32 | Slot A redirect address |
| ra_kill | input | 1 | Slot A result: suppress the following step |
| rb_branch | input | 1 | Slot B (parallel integer) redirect requested |
| rb_target | input | 32 | Slot B redirect address |
| commit | output | 1 | Pulse one cycle after each issue step |
| done | output | 1 | Pulse when the word is finished |
| npc_valid | output | 1 | Merged next-PC is present (with done) |
| npc | output | 32 | Merged next-PC address |
| conflict | output | 1 | Both parallel slots redirected (with done) |

## Verification
Issue strobes and their operands are due in the first cycle after the edge that accepts a word. A second ordered step comes one cycle later. `commit`, `done`, `npc_valid`, `npc` and `conflict` are registered, so each is due one cycle after the step that produced it. The bench drives the slot results ahead of each step cycle and changes them on falling edges only. It samples every output on the falling edge of the exact cycle in which the result is due. To show that a word offered while busy is ignored, the bench samples one extra cycle after `done`.

// File: rtl/dic_pkg.sv
package dic_pkg;
  typedef enum logic [1:0] {
    FMT_PAR  = 2'd0,
    FMT_L2R  = 2'd1,
    FMT_R2L  = 2'd2,
    FMT_LONG = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  function automatic logic is_ordered(fmt_e f);
    return (f == FMT_L2R) || (f == FMT_R2L);
  endfunction
endpackage

// File: rtl/dic_fsm.sv
module dic_fsm
  import dic_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  fmt_e   fmt,
  input  logic   stop_early,
  output phase_e phase,
  output logic   finish
);
  phase_e phase_q, phase_d;
  logic   go_second;

  always_comb begin
    go_second = is_ordered(fmt) && !stop_early;
    phase_d   = phase_q;
    finish    = 1'b0;
    case (phase_q)
      PH_IDLE:   if (accept) phase_d = PH_FIRST;
      PH_FIRST: begin
        if (go_second) begin
          phase_d = PH_SECOND;
        end else begin
          phase_d = PH_IDLE;
          finish  = 1'b1;
        end
      end
      PH_SECOND: begin
        phase_d = PH_IDLE;
        finish  = 1'b1;
      end
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/dic_route.sv
module dic_route
  import dic_pkg::*;
#(
  parameter int IW = 32
) (
  input  fmt_e            fmt,
  input  phase_e          phase,
  input  logic [2*IW-1:0] word,
  output logic            mem_go,
  output logic [IW-1:0]   mem_op,
  output logic            int_go,
  output logic [IW-1:0]   int_op,
  output logic            any_go,
  output logic [IW-1:0]   any_op,
  output logic            long_go,
  output logic [2*IW-1:0] long_op
);
  logic [IW-1:0] left_half, right_half;
  logic          first, second;

  assign left_half  = word[2*IW-1:IW];
  assign right_half = word[IW-1:0];
  assign first      = (phase == PH_FIRST);
  assign second     = (phase == PH_SECOND);

  always_comb begin
    mem_go  = first && (fmt == FMT_PAR || fmt == FMT_L2R);
    int_go  = first && (fmt == FMT_PAR || fmt == FMT_R2L);
    long_go = first && (fmt == FMT_LONG);
    any_go  = second;
    mem_op  = mem_go  ? left_half  : '0;
    int_op  = int_go  ? right_half : '0;
    long_op = long_go ? word       : '0;
    if (!any_go)               any_op = '0;
    else if (fmt == FMT_L2R)   any_op = right_half;
    else                       any_op = left_half;
  end
endmodule

// File: rtl/dic_merge.sv
module dic_merge
  import dic_pkg::*;
#(
  parameter int AW = 32
) (
  input  fmt_e          fmt,
  input  logic          a_branch,
  input  logic [AW-1:0] a_target,
  input  logic          b_branch,
  input  logic [AW-1:0] b_target,
  output logic          tgt_valid,
  output logic [AW-1:0] tgt_addr,
  output logic          clash
);
  always_comb begin
    tgt_valid = 1'b0;
    tgt_addr  = a_target;
    clash     = 1'b0;
    if (fmt == FMT_PAR) begin
      if (a_branch && b_branch) begin
        clash = 1'b1;
      end else if (b_branch) begin
        tgt_valid = 1'b1;
        tgt_addr  = b_target;
      end else begin
        tgt_valid = a_branch;
      end
    end else begin
      tgt_valid = a_branch;
    end
  end
endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
  import dic_pkg::*;
#(
  parameter int IW = 32,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_valid,
  output logic            word_ready,
  input  logic [2*IW-1:0] word_in,
  output logic            mem_go,
  output logic [IW-1:0]   mem_op,
  output logic            int_go,
  output logic [IW-1:0]   int_op,
  output logic            any_go,
  output logic [IW-1:0]   any_op,
  output logic            long_go,
  output logic [2*IW-1:0] long_op,
  input  logic            ra_branch,
  input  logic [AW-1:0]   ra_target,
  input  logic            ra_kill,
  input  logic            rb_branch,
  input  logic [AW-1:0]   rb_target,
  output logic            commit,
  output logic            done,
  output logic            npc_valid,
  output logic [AW-1:0]   npc,
  output logic            conflict
);
  localparam int WW     = 2 * IW;
  localparam int FMT_HI = WW - 1;
  localparam int FMT_LO = IW - 1;

  logic [WW-1:0] word_q;
  fmt_e          fmt;
  phase_e        phase;
  logic          accept, finish, step_act, stop_early;
  logic          m_valid, m_clash;
  logic [AW-1:0] m_addr;

  assign fmt        = fmt_e'({word_q[FMT_HI], word_q[FMT_LO]});
  assign word_ready = (phase == PH_IDLE);
  assign accept     = word_valid && word_ready;
  assign step_act   = (phase != PH_IDLE);
  assign stop_early = ra_branch || ra_kill;

  always_ff @(posedge clk) begin
    if (accept) word_q <= word_in;
  end

  dic_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .fmt        (fmt),
    .stop_early (stop_early),
    .phase      (phase),
    .finish     (finish)
  );

  dic_route #(.IW(IW)) u_route (
    .fmt     (fmt),
    .phase   (phase),
    .word    (word_q),
    .mem_go  (mem_go),
    .mem_op  (mem_op),
    .int_go  (int_go),
    .int_op  (int_op),
    .any_go  (any_go),
    .any_op  (any_op),
    .long_go (long_go),
    .long_op (long_op)
  );

  dic_merge #(.AW(AW)) u_merge (
    .fmt       (fmt),
    .a_branch  (ra_branch),
    .a_target  (ra_target),
    .b_branch  (rb_branch),
    .b_target  (rb_target),
    .tgt_valid (m_valid),
    .tgt_addr  (m_addr),
    .clash     (m_clash)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit    <= 1'b0;
      done      <= 1'b0;
      npc_valid <= 1'b0;
      conflict  <= 1'b0;
    end else begin
      commit    <= step_act;
      done      <= finish;
      npc_valid <= finish && m_valid;
      conflict  <= finish && m_clash;
    end
  end

  always_ff @(posedge clk) begin
    if (finish) npc <= m_addr;
  end
endmodule

// File: rtl/dic_checker.sv
module dic_checker (
  input logic clk,
  input logic rst_n,
  input logic word_ready,
  input logic mem_go,
  input logic int_go,
  input logic any_go,
  input logic long_go,
  input logic commit,
  input logic done,
  input logic npc_valid,
  input logic conflict
);
  logic issuing;
  assign issuing = mem_go || int_go || any_go || long_go;

  assert_long_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    long_go |-> !(mem_go || int_go || any_go));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issuing |-> !word_ready);

  assert_commit_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issuing |=> commit);

  assert_commit_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(issuing));

  assert_second_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |-> $past(mem_go != int_go));

  assert_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (done && !npc_valid));
endmodule

bind dual_issue_ctrl dic_checker u_dic_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_ready (word_ready),
  .mem_go     (mem_go),
  .int_go     (int_go),
  .any_go     (any_go),
  .long_go    (long_go),
  .commit     (commit),
  .done       (done),
  .npc_valid  (npc_valid),
  .conflict   (conflict)
);

// File: tb/dual_issue_ctrl_bench.sv
module dual_issue_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_valid;
  logic        word_ready;
  logic [63:0] word_in;
  logic        mem_go, int_go, any_go, long_go;
  logic [31:0] mem_op, int_op, any_op;
  logic [63:0] long_op;
  logic        ra_branch, ra_kill, rb_branch;
  logic [31:0] ra_target, rb_target;
  logic        commit, done, npc_valid, conflict;
  logic [31:0] npc;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dual_issue_ctrl u_dual_issue_ctrl (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_in(word_in), .mem_go(mem_go), .mem_op(mem_op), .int_go(int_go),
    .int_op(int_op), .any_go(any_go), .any_op(any_op), .long_go(long_go),
    .long_op(long_op), .ra_branch(ra_branch), .ra_target(ra_target),
    .ra_kill(ra_kill), .rb_branch(rb_branch), .rb_target(rb_target),
    .commit(commit), .done(done), .npc_valid(npc_valid), .npc(npc),
    .conflict(conflict)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit two_steps(input logic [63:0] w, input bit b1, input bit k1);
    logic [1:0] f;
    f = {w[63], w[31]};
    return (f == 2'd1 || f == 2'd2) && !b1 && !k1;
  endfunction

  task automatic run_word(input logic [63:0] w,
                          input bit a1b, input logic [31:0] a1t, input bit a1k,
                          input bit bb,  input logic [31:0] bt,
                          input bit a2b, input logic [31:0] a2t, input bit a2k,
                          input bit poke);
    logic [1:0]  f;
    bit          two, ev, ec;
    logic [31:0] et;
    f   = {w[63], w[31]};
    two = two_steps(w, a1b, a1k);
    ec  = 1'b0;
    if (f == 2'd0) begin
      ec = a1b && bb;
      ev = a1b ^ bb;
      et = a1b ? a1t : bt;
    end else if (two) begin
      ev = a2b; et = a2t;
    end else begin
      ev = a1b; et = a1t;
    end

    @(negedge clk);
    chk("R10 ready idle", 64'(word_ready), 64'd1);
    word_valid = 1'b1; word_in = w;
    ra_branch = a1b; ra_target = a1t; ra_kill = a1k;
    rb_branch = bb;  rb_target = bt;

    @(negedge clk);
    word_valid = poke;
    if (poke) word_in = ~w;
    chk("R10 ready busy", 64'(word_ready), 64'd0);
    chk("R3 R4 mem_go", 64'(mem_go), 64'(f == 2'd0 || f == 2'd1));
    chk("R3 R5 int_go", 64'(int_go), 64'(f == 2'd0 || f == 2'd2));
    chk("R2 long_go", 64'(long_go), 64'(f == 2'd3));
    chk("R2 any_go step1", 64'(any_go), 64'd0);
    chk("R3 R4 mem_op", 64'(mem_op), (f == 2'd0 || f == 2'd1) ? 64'(w[63:32]) : 64'd0);
    chk("R3 R5 int_op", 64'(int_op), (f == 2'd0 || f == 2'd2) ? 64'(w[31:0]) : 64'd0);
    chk("R2 long_op", long_op, (f == 2'd3) ? w : 64'd0);
    chk("R6 no commit in step", 64'(commit), 64'd0);

    @(negedge clk);
    chk("R6 commit step1", 64'(commit), 64'd1);
    if (two) begin
      chk("R4 R5 any_go", 64'(any_go), 64'd1);
      chk("R4 R5 any_op", 64'(any_op), (f == 2'd1) ? 64'(w[31:0]) : 64'(w[63:32]));
      chk("R4 R5 first units off", 64'({mem_go, int_go, long_go}), 64'd0);
      chk("R6 not done early", 64'(done), 64'd0);
      ra_branch = a2b; ra_target = a2t; ra_kill = a2k;
      @(negedge clk);
      chk("R6 commit step2", 64'(commit), 64'd1);
      chk("R11 step2 kill ignored any_go", 64'(any_go), 64'd0);
    end else begin
      chk("R7 no second step", 64'(any_go), 64'd0);
    end
    word_valid = 1'b0;
    chk("R7 done", 64'(done), 64'd1);
    chk("R8 npc_valid", 64'(npc_valid), 64'(ev));
    chk("R9 conflict", 64'(conflict), 64'(ec));
    if (ev) chk("R8 R11 npc", 64'(npc), 64'(et));
    if (poke) begin
      @(negedge clk);
      chk("R10 poke no issue", 64'({mem_go, int_go, any_go, long_go}), 64'd0);
      chk("R10 poke no done", 64'(done), 64'd0);
    end
  endtask

  function automatic logic [63:0] mk(input logic [1:0] f, input logic [63:0] r);
    logic [63:0] w;
    w = r;
    w[63] = f[1];
    w[31] = f[0];
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0dd5_eed1));
    rst_n = 1'b0; word_valid = 1'b0; word_in = '0;
    ra_branch = 1'b0; ra_target = '0; ra_kill = 1'b0;
    rb_branch = 1'b0; rb_target = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready", 64'(word_ready), 64'd1);
    chk("R1 strobes", 64'({mem_go, int_go, any_go, long_go}), 64'd0);
    chk("R1 outputs", 64'({commit, done, npc_valid, conflict}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 64'({commit, done, word_ready}), 64'd1);

    // directed corner cases
    run_word(mk(2'd3, 64'h1234_5678_9abc_def0), 0, 0, 1, 0, 0, 0, 0, 0, 0);          // R2 R11 long with kill
    run_word(mk(2'd3, 64'h0f0f_0000_aaaa_5555), 1, 32'h100, 0, 0, 0, 0, 0, 0, 0);    // R2 long branch
    run_word(mk(2'd0, 64'h1111_2222_3333_4444), 0, 0, 1, 0, 0, 0, 0, 0, 0);          // R11 parallel kill
    run_word(mk(2'd0, 64'h5555_6666_7777_8888), 1, 32'hA0, 0, 0, 32'hB0, 0, 0, 0, 0); // R8 slot A
    run_word(mk(2'd0, 64'h5555_6666_7777_8888), 0, 32'hA0, 0, 1, 32'hB0, 0, 0, 0, 0); // R8 slot B
    run_word(mk(2'd0, 64'h9999_aaaa_bbbb_cccc), 1, 32'hA0, 0, 1, 32'hB0, 0, 0, 0, 0); // R9 clash
    run_word(mk(2'd1, 64'h0102_0304_0506_0708), 0, 0, 0, 0, 0, 1, 32'hC4, 1, 0);     // R4 R11 step2 kill
    run_word(mk(2'd2, 64'h0102_0304_0506_0708), 0, 0, 0, 0, 0, 0, 0, 0, 0);          // R5 plain
    run_word(mk(2'd1, 64'hdead_beef_cafe_f00d), 1, 32'hD0, 0, 0, 0, 0, 0, 0, 0);     // R7 branch cancels
    run_word(mk(2'd2, 64'hdead_beef_cafe_f00d), 0, 0, 1, 0, 0, 0, 0, 0, 0);          // R7 kill cancels
    run_word(mk(2'd1, 64'h4444_3333_2222_1111), 0, 0, 0, 0, 0, 0, 0, 0, 1);          // R10 poke while busy
    run_word(mk(2'd3, 64'h4444_3333_2222_1111), 0, 0, 0, 0, 0, 0, 0, 0, 1);          // R10 poke one step

    for (int i = 0; i < 400; i++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      run_word(w, ($urandom % 3) == 0, $urandom, ($urandom % 4) == 0,
               ($urandom % 3) == 0, $urandom,
               ($urandom % 2) == 0, $urandom, ($urandom % 3) == 0,
               ($urandom % 8) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule